// File: doc/BRIEF.md
# Register Renamer with Move and Zeroing Elimination

This block renames one instruction per cycle, translating 16 architectural register indices into tags from a larger pool of physical registers. Each instruction comes with a class, two source indices and a destination index. The block returns three things: the physical tags of the sources, the physical tag assigned to the destination, and a flag that says whether the instruction still has to go to an execution unit.

Two kinds of instruction are finished entirely at rename and never reach execution:

- A register-to-register copy. The destination's map entry is pointed at the physical register the source already holds.
- An exclusive-or of a register with itself. The destination is pointed at a hard-wired zero register (tag 0).

Because the map changes in the same cycle, the very next instruction already reads the shared tag.

Every physical register carries a small reference counter. When a copy would push a counter past its ceiling, the copy is not eliminated: it takes a fresh register and executes. The retirement side hands back old mappings through a release port. A register returns to the free pool only when its count reaches zero. When an instruction needs a fresh register and none is free, the block stalls.

Top module: `rn_move_elim_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i+1. Registers NUM_ARCH+1 to NUM_PHYS-1 are free. Tag 0 is the zero register. No rename fires and no stall is raised while `in_valid` is low.
- R2: Class encodings are 0 register copy, 1 exclusive-or, 2 other ALU, 3 load, 4 immediate move. ALU, load and immediate-move instructions always execute (`out_exec`=1). Their destination gets the lowest-numbered free physical register. `out_pold` reports the destination's previous mapping.
- R3: A register copy (class 0) whose source register's count is below the ceiling sets `out_exec`=0. It returns the source's physical tag as `out_pdst` and takes no register from the pool.
- R4: Source tags are the current map entries of the source index fields, whatever the class. An instruction in the cycle right after an eliminated copy reads the copied-from tag for the copy's destination.
- R5: An exclusive-or whose two source indices are equal returns `out_pdst`=0 and `out_exec`=0. Later readers of its destination see tag 0.
- R6: An exclusive-or of two different registers is renamed like an ALU instruction and executes.
- R7: A register copy whose source physical register already has a count of 2^RC_W-1 falls back to execution. It takes a fresh register with `out_exec`=1.
- R8: A register copy from a register mapped to tag 0 is always eliminated, however many times it repeats.
- R9: When an instruction needs a fresh register and the pool is empty, `rn_stall`=1, `out_fire`=0 and the map is left unchanged. Eliminated copies and zeroing exclusive-ors still fire while the pool is empty.
- R10: A release decrements the count of `rel_preg`. That register becomes allocatable again only when its count reaches zero.
- R11: A release of tag 0 has no effect on the pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_class | input | 3 | Instruction class (see R2) |
| in_src_a | input | AW | First source architectural index |
| in_src_b | input | AW | Second source architectural index |
| in_dst | input | AW | Destination architectural index |
| rel_valid | input | 1 | Release request |
| rel_preg | input | PW | Physical register being released |
| rn_stall | output | 1 | Instruction held: no free register |
| out_fire | output | 1 | Instruction renamed this cycle |
| out_psrc_a | output | PW | Physical tag of first source |
| out_psrc_b | output | PW | Physical tag of second source |
| out_pdst | output | PW | Physical tag for destination |
| out_pold | output | PW | Previous physical tag of destination |
| out_exec | output | 1 | Instruction must be executed |

## Verification
The bench builds the block with NUM_PHYS=24 and RC_W=2. That leaves only seven free registers after reset, so a short stream of instructions empties the pool and reaches the stall path. The ceiling of three references is reached after two copies from the same source, so the fallback-to-execution case appears early. The same small pool makes it quick to release registers step by step and watch one become allocatable only on its final release.

// File: rtl/rn_pkg.sv
package rn_pkg;

  typedef enum logic [2:0] {
    CLS_MOVRR  = 3'd0,
    CLS_XOR    = 3'd1,
    CLS_ALU    = 3'd2,
    CLS_LOAD   = 3'd3,
    CLS_MOVIMM = 3'd4
  } insn_class_e;

  // Copy may share the source register when it is the zero register
  // or when its reference count still has headroom.
  function automatic logic copy_can_share(input logic src_is_zero,
                                          input logic src_saturated);
    return src_is_zero || !src_saturated;
  endfunction

  // Zeroing idiom: exclusive-or of an index with itself.
  function automatic logic is_zero_idiom(input insn_class_e cls,
                                         input logic same_src);
    return (cls == CLS_XOR) && same_src;
  endfunction

endpackage

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
  parameter int NUM_PHYS = 48,
  parameter int NUM_ARCH = 16,
  parameter int PW       = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          give,
  input  logic [PW-1:0] give_idx,
  output logic          avail,
  output logic [PW-1:0] alloc_idx
);

  logic [NUM_PHYS-1:0] free_q;

  // Lowest-numbered free register wins.
  always_comb begin
    avail     = 1'b0;
    alloc_idx = '0;
    for (int i = NUM_PHYS - 1; i >= 1; i--) begin
      if (free_q[i]) begin
        avail     = 1'b1;
        alloc_idx = PW'(i);
      end
    end
  end

  for (genvar g = 0; g < NUM_PHYS; g++) begin : g_slot
    if (g == 0) begin : g_zero
      assign free_q[g] = 1'b0;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n)
          free_q[g] <= (g > NUM_ARCH);
        else if (take && alloc_idx == PW'(g))
          free_q[g] <= 1'b0;
        else if (give && give_idx == PW'(g))
          free_q[g] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rn_refcnt.sv
module rn_refcnt #(
  parameter int NUM_PHYS = 48,
  parameter int NUM_ARCH = 16,
  parameter int PW       = 6,
  parameter int RC_W     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic [PW-1:0] inc_idx,
  input  logic          dec,
  input  logic [PW-1:0] dec_idx,
  input  logic [PW-1:0] q_idx,
  output logic          q_saturated,
  output logic          freed
);

  localparam logic [RC_W-1:0] CNT_MAX = {RC_W{1'b1}};

  logic [RC_W-1:0] cnt_q [NUM_PHYS];
  logic            dec_live;
  logic            inc_same;

  assign q_saturated = (cnt_q[q_idx] == CNT_MAX);
  assign dec_live    = dec && (dec_idx != '0) && (cnt_q[dec_idx] != '0);
  assign inc_same    = inc && (inc_idx == dec_idx);
  assign freed       = dec_live && (cnt_q[dec_idx] == RC_W'(1)) && !inc_same;

  for (genvar g = 0; g < NUM_PHYS; g++) begin : g_cnt
    if (g == 0) begin : g_zero
      assign cnt_q[g] = '0;
    end else begin : g_reg
      logic inc_hit;
      logic dec_hit;
      assign inc_hit = inc && (inc_idx == PW'(g));
      assign dec_hit = dec_live && (dec_idx == PW'(g));
      always_ff @(posedge clk) begin
        if (!rst_n)
          cnt_q[g] <= (g <= NUM_ARCH) ? RC_W'(1) : '0;
        else
          cnt_q[g] <= cnt_q[g] + RC_W'(inc_hit) - RC_W'(dec_hit);
      end
    end
  end

endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NUM_ARCH = 16,
  parameter int AW       = 4,
  parameter int PW       = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  input  logic [AW-1:0] rd,
  output logic [PW-1:0] pa,
  output logic [PW-1:0] pb,
  output logic [PW-1:0] pd,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [PW-1:0] wdata
);

  logic [PW-1:0] map_q [NUM_ARCH];

  assign pa = map_q[ra];
  assign pb = map_q[rb];
  assign pd = map_q[rd];

  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        map_q[g] <= PW'(g + 1);
      else if (we && wa == AW'(g))
        map_q[g] <= wdata;
    end
  end

endmodule

// File: rtl/rn_move_elim_rename.sv
module rn_move_elim_rename #(
  parameter int NUM_ARCH = 16,
  parameter int NUM_PHYS = 48,
  parameter int RC_W     = 2,
  localparam int AW      = $clog2(NUM_ARCH),
  localparam int PW      = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    in_class,
  input  logic [AW-1:0] in_src_a,
  input  logic [AW-1:0] in_src_b,
  input  logic [AW-1:0] in_dst,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_preg,
  output logic          rn_stall,
  output logic          out_fire,
  output logic [PW-1:0] out_psrc_a,
  output logic [PW-1:0] out_psrc_b,
  output logic [PW-1:0] out_pdst,
  output logic [PW-1:0] out_pold,
  output logic          out_exec
);
  import rn_pkg::*;

  insn_class_e   cls;
  logic          zero_idiom;
  logic          copy_elim;
  logic          no_exec;
  logic          src_saturated;
  logic          src_is_zero;
  logic          pool_avail;
  logic [PW-1:0] alloc_idx;
  logic          alloc_take;
  logic          cnt_inc;
  logic [PW-1:0] cnt_inc_idx;
  logic          freed_evt;

  assign cls         = insn_class_e'(in_class);
  assign src_is_zero = (out_psrc_a == '0);
  assign zero_idiom  = is_zero_idiom(cls, in_src_a == in_src_b);
  assign copy_elim   = (cls == CLS_MOVRR) && copy_can_share(src_is_zero, src_saturated);
  assign no_exec     = zero_idiom || copy_elim;

  assign rn_stall    = in_valid && !no_exec && !pool_avail;
  assign out_fire    = in_valid && !rn_stall;
  assign alloc_take  = out_fire && !no_exec;
  assign out_exec    = !no_exec;

  always_comb begin
    if (zero_idiom)     out_pdst = '0;
    else if (copy_elim) out_pdst = out_psrc_a;
    else                out_pdst = alloc_idx;
  end

  assign cnt_inc     = alloc_take || (out_fire && copy_elim && !zero_idiom && !src_is_zero);
  assign cnt_inc_idx = alloc_take ? alloc_idx : out_psrc_a;

  rn_map_table #(.NUM_ARCH(NUM_ARCH), .AW(AW), .PW(PW)) u_map (
    .clk   (clk),
    .rst_n (rst_n),
    .ra    (in_src_a),
    .rb    (in_src_b),
    .rd    (in_dst),
    .pa    (out_psrc_a),
    .pb    (out_psrc_b),
    .pd    (out_pold),
    .we    (out_fire),
    .wa    (in_dst),
    .wdata (out_pdst)
  );

  rn_refcnt #(.NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH), .PW(PW), .RC_W(RC_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .inc         (cnt_inc),
    .inc_idx     (cnt_inc_idx),
    .dec         (rel_valid),
    .dec_idx     (rel_preg),
    .q_idx       (out_psrc_a),
    .q_saturated (src_saturated),
    .freed       (freed_evt)
  );

  rn_free_pool #(.NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH), .PW(PW)) u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (alloc_take),
    .give      (freed_evt),
    .give_idx  (rel_preg),
    .avail     (pool_avail),
    .alloc_idx (alloc_idx)
  );

endmodule

// File: rtl/rn_rename_checker.sv
module rn_rename_checker #(
  parameter int AW = 4,
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [2:0]    in_class,
  input logic [AW-1:0] in_src_a,
  input logic [AW-1:0] in_src_b,
  input logic          out_fire,
  input logic          rn_stall,
  input logic [PW-1:0] out_psrc_a,
  input logic [PW-1:0] out_pdst,
  input logic          out_exec,
  input logic          alloc_take,
  input logic          pool_avail,
  input logic [PW-1:0] rel_preg,
  input logic          freed_evt
);

  a_r3_elim_takes_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && !out_exec |-> !alloc_take);

  a_r3_copy_shares_source: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && in_class == 3'd0 && !out_exec |-> out_pdst == out_psrc_a);

  a_r5_zero_idiom: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && in_class == 3'd1 && in_src_a == in_src_b |-> out_pdst == '0 && !out_exec);

  a_r2_fresh_dest: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_exec |-> out_pdst != '0 && out_pdst != out_psrc_a);

  a_r9_stall_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rn_stall |-> !pool_avail && in_valid);

  a_r11_zero_not_freed: assert property (@(posedge clk) disable iff (!rst_n)
    freed_evt |-> rel_preg != '0);

  a_r10_freed_usable: assert property (@(posedge clk) disable iff (!rst_n)
    freed_evt |=> pool_avail);

endmodule

bind rn_move_elim_rename rn_rename_checker #(.AW(AW), .PW(PW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_class   (in_class),
  .in_src_a   (in_src_a),
  .in_src_b   (in_src_b),
  .out_fire   (out_fire),
  .rn_stall   (rn_stall),
  .out_psrc_a (out_psrc_a),
  .out_pdst   (out_pdst),
  .out_exec   (out_exec),
  .alloc_take (alloc_take),
  .pool_avail (pool_avail),
  .rel_preg   (rel_preg),
  .freed_evt  (freed_evt)
);

// File: tb/rn_move_elim_rename_bench.sv
module rn_move_elim_rename_bench;
  localparam int NA = 16;
  localparam int NP = 24;
  localparam int RC = 2;
  localparam int CMAX = (1 << RC) - 1;
  localparam int AW = $clog2(NA);
  localparam int PW = $clog2(NP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] in_class = '0;
  logic [AW-1:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic rel_valid = 1'b0;
  logic [PW-1:0] rel_preg = '0;
  logic rn_stall, out_fire, out_exec;
  logic [PW-1:0] out_psrc_a, out_psrc_b, out_pdst, out_pold;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rn_move_elim_rename #(.NUM_ARCH(NA), .NUM_PHYS(NP), .RC_W(RC)) u_rn_move_elim_rename (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
    .rel_valid(rel_valid), .rel_preg(rel_preg), .rn_stall(rn_stall),
    .out_fire(out_fire), .out_psrc_a(out_psrc_a), .out_psrc_b(out_psrc_b),
    .out_pdst(out_pdst), .out_pold(out_pold), .out_exec(out_exec));

  typedef struct {
    bit    stall;
    int    psa, psb, pdst, pold;
    bit    ex;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  // Requirement-level model
  int m_map[NA];
  int m_cnt[NP];
  bit m_free[NP];

  task automatic model_reset();
    for (int i = 0; i < NA; i++) m_map[i] = i + 1;
    for (int p = 0; p < NP; p++) begin
      m_cnt[p]  = (p >= 1 && p <= NA) ? 1 : 0;
      m_free[p] = (p > NA);
    end
  endtask

  task automatic issue(input int cls, input int a, input int b, input int d, input string tag);
    exp_t e;
    int lo;
    @(posedge clk); #1;
    rel_valid = 1'b0;
    in_valid = 1'b1; in_class = 3'(cls);
    in_src_a = AW'(a); in_src_b = AW'(b); in_dst = AW'(d);
    e.tag = tag; e.stall = 0;
    e.psa = m_map[a]; e.psb = m_map[b]; e.pold = m_map[d];
    if (cls == 1 && a == b) begin
      e.pdst = 0; e.ex = 0;
    end else if (cls == 0 && (e.psa == 0 || m_cnt[e.psa] < CMAX)) begin
      e.pdst = e.psa; e.ex = 0;
      if (e.psa != 0) m_cnt[e.psa]++;
    end else begin
      lo = -1;
      for (int p = NP - 1; p >= 1; p--) if (m_free[p]) lo = p;
      e.ex = 1;
      if (lo < 0) begin
        e.stall = 1; e.pdst = 0;
      end else begin
        e.pdst = lo; m_free[lo] = 0; m_cnt[lo] = 1;
      end
    end
    if (!e.stall) m_map[d] = e.pdst;
    exp_q.push_back(e);
  endtask

  task automatic release_reg(input int p);
    @(posedge clk); #1;
    in_valid = 1'b0;
    rel_valid = 1'b1; rel_preg = PW'(p);
    if (p != 0 && m_cnt[p] > 0) begin
      m_cnt[p]--;
      if (m_cnt[p] == 0) m_free[p] = 1;
    end
  endtask

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 1'b0; rel_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && in_valid) begin
      exp_t e;
      bit ok;
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: output without expected item");
      end else begin
        e = exp_q.pop_front();
        checks++;
        ok = (rn_stall == e.stall) && (out_fire == !e.stall)
          && (int'(out_psrc_a) == e.psa) && (int'(out_psrc_b) == e.psb)
          && (int'(out_pold) == e.pold);
        if (!e.stall) ok = ok && (int'(out_pdst) == e.pdst) && (out_exec == e.ex);
        if (!ok) begin
          errors++;
          $display("FAIL %s: got stall=%0d fire=%0d psa=%0d psb=%0d pdst=%0d pold=%0d exec=%0d; expected stall=%0d psa=%0d psb=%0d pdst=%0d pold=%0d exec=%0d",
                   e.tag, rn_stall, out_fire, out_psrc_a, out_psrc_b, out_pdst, out_pold, out_exec,
                   e.stall, e.psa, e.psb, e.pdst, e.pold, e.ex);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rn_stall !== 1'b0 || out_fire !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset idle: got stall=%0d fire=%0d expected 0 0", rn_stall, out_fire);
    end
    issue(2, 1, 2, 0, "R1 R2 alu after reset");          // 17
    issue(0, 0, 0, 3, "R3 copy eliminated");             // share 17
    issue(2, 3, 3, 4, "R4 reader of copy dest");         // 18
    issue(0, 0, 0, 5, "R3 second copy");                 // 17 count 3
    issue(0, 0, 0, 6, "R7 copy at ceiling executes");    // 19
    issue(1, 7, 7, 7, "R5 zeroing xor");
    issue(2, 7, 7, 8, "R5 reader of zeroed reg");        // 20
    for (int k = 0; k < 4; k++) issue(0, 7, 7, 9, "R8 copy from zero reg");
    issue(1, 10, 11, 10, "R6 xor of distinct regs");     // 21
    issue(3, 12, 12, 12, "R2 load executes");            // 22
    issue(4, 0, 0, 13, "R2 immediate move executes");    // 23
    issue(2, 1, 2, 14, "R9 stall on empty pool");
    issue(0, 0, 0, 15, "R9 R7 saturated copy stalls");
    issue(1, 15, 15, 15, "R9 zeroing xor while empty");
    issue(0, 4, 4, 14, "R9 copy eliminated while empty");
    release_reg(17);
    release_reg(0);
    issue(2, 1, 2, 11, "R10 R11 still stalled");
    release_reg(17);
    issue(2, 1, 2, 11, "R10 one ref left");
    release_reg(17);
    issue(2, 1, 2, 11, "R10 freed reg reused");          // 17
    release_reg(1);
    issue(2, 5, 6, 2, "R10 old mapping reused");         // 1
    issue(2, 0, 1, 3, "R9 empty again");
    idle();
    idle();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule